// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer

This block keeps a bank of single-bit storage cells, selected by a binary address, and shows every cell on its own parallel output. One data input, an address, an active-low enable and an active-low clear control the bank. Taken together, the two control inputs pick one of four modes: write one addressed bit, freeze the whole bank, act as a 1-to-N demultiplexer or binary decoder, or clear everything.

The design is clocked. Writes take effect on the rising clock edge while the enable is low and the clear is high. In decode mode and clear mode the outputs are driven combinationally from the address and data, so they respond in the same cycle. In every other mode the outputs come straight from the storage register. A synchronous active-high reset empties the bank.

Top module: `addr_latch`

## Requirements
- R1: While `rst_i` is high at a rising edge, every storage bit becomes 0. After that edge, in hold mode, `q_o` reads all zeros.
- R2: The mode comes from {`clr_n_i`,`en_n_i`}. 2'b10 is write, 2'b11 is hold, 2'b00 is decode and 2'b01 is clear.
- R3: In write mode, the bit selected by `addr_i` (bit index = address value) takes `din_i` at the rising edge. The new value shows on `q_o` after that edge. All other bits keep their values.
- R4: In hold mode, the stored bits do not change, whatever `addr_i` and `din_i` do.
- R5: In decode mode, `q_o[addr_i]` equals `din_i` and every other output bit is 0. This is combinational and holds in the same cycle.
- R6: In clear mode, `q_o` is all zeros in the same cycle, independent of `addr_i` and `din_i`.
- R7: A rising edge in decode mode or in clear mode empties the storage register. A hold mode that follows therefore shows all zeros.
- R8: In write mode, only the address and data present at the rising edge are stored. Address changes between edges, even across several bits, write nothing.
- R9: In write mode and in hold mode, `q_o` equals the storage register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| clr_n_i | input | 1 | Clear control, active low (mode select bit 1) |
| en_n_i | input | 1 | Enable control, active low (mode select bit 0) |
| addr_i | input | ADDR_W | Bit address |
| din_i | input | 1 | Data bit |
| q_o | output | 2**ADDR_W | Parallel outputs, one per cell |

## Verification
The synchronous reset can arrive in the same cycle as a write-mode edge, and the two then compete for the addressed cell. The random stream raises `rst_i` in a small share of cycles, on top of randomly chosen modes, so a reset regularly meets a write, a decode or a hold. The bench model gives reset priority at the edge. In that cycle it still expects the combinational outputs that the selected mode implies. A surviving written bit would show up as a mismatch in the next hold or write cycle.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_DECODE = 2'b00,
    MODE_CLEAR  = 2'b01,
    MODE_WRITE  = 2'b10,
    MODE_HOLD   = 2'b11
  } mode_e;
endpackage

// File: rtl/addr_latch_mode.sv
module addr_latch_mode
  import addr_latch_pkg::*;
(
  input  logic  clr_n_i,
  input  logic  en_n_i,
  output mode_e mode_o
);
  // Mode is the two control pins taken as a 2-bit code.
  always_comb begin
    unique case ({clr_n_i, en_n_i})
      2'b10:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_DECODE;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/addr_latch_cells.sv
module addr_latch_cells
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  mode_e             mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic [NUM-1:0]    store_o
);
  logic wipe;
  assign wipe = rst_i || (mode_i == MODE_DECODE) || (mode_i == MODE_CLEAR);

  for (genvar i = 0; i < NUM; i++) begin : g_cell
    logic cell_q;
    logic hit;
    assign hit = (mode_i == MODE_WRITE) && (addr_i == ADDR_W'(i));
    always_ff @(posedge clk_i) begin
      if (wipe)     cell_q <= 1'b0;
      else if (hit) cell_q <= din_i;
    end
    assign store_o[i] = cell_q;
  end
endmodule

// File: rtl/addr_latch_out.sv
module addr_latch_out
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM = 1 << ADDR_W
) (
  input  mode_e             mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  input  logic [NUM-1:0]    store_i,
  output logic [NUM-1:0]    q_o
);
  logic [NUM-1:0] demux;

  always_comb begin
    for (int i = 0; i < NUM; i++) begin
      demux[i] = din_i && (addr_i == ADDR_W'(i));
    end
  end

  always_comb begin
    unique case (mode_i)
      MODE_DECODE: q_o = demux;
      MODE_CLEAR:  q_o = '0;
      default:     q_o = store_i;
    endcase
  end
endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              clr_n_i,
  input  logic              en_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic [NUM-1:0]    q_o
);
  mode_e          mode;
  logic [NUM-1:0] store_q;

  addr_latch_mode u_mode (
    .clr_n_i (clr_n_i),
    .en_n_i  (en_n_i),
    .mode_o  (mode)
  );

  addr_latch_cells #(.ADDR_W(ADDR_W)) u_cells (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .mode_i  (mode),
    .addr_i  (addr_i),
    .din_i   (din_i),
    .store_o (store_q)
  );

  addr_latch_out #(.ADDR_W(ADDR_W)) u_out (
    .mode_i  (mode),
    .addr_i  (addr_i),
    .din_i   (din_i),
    .store_i (store_q),
    .q_o     (q_o)
  );
endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
  parameter int ADDR_W = 3,
  localparam int NUM = 1 << ADDR_W
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              clr_n_i,
  input logic              en_n_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              din_i,
  input logic [NUM-1:0]    q_o,
  input logic [NUM-1:0]    store_q
);
  a_r1_reset_empties: assert property (@(posedge clk_i)
    rst_i |=> store_q == '0);

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_n_i && !en_n_i) |=> store_q[$past(addr_i)] == $past(din_i));

  a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_n_i && en_n_i) |=> $stable(store_q));

  a_r5_decode_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_n_i && !en_n_i) |-> ($onehot0(q_o) && q_o[addr_i] == din_i));

  a_r6_clear_low: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_n_i && en_n_i) |-> q_o == '0);

  a_r7_wipe_store: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_n_i |=> store_q == '0);

  a_r9_out_follows_store: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_n_i |-> q_o == store_q);
endmodule

bind addr_latch addr_latch_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .clr_n_i (clr_n_i),
  .en_n_i  (en_n_i),
  .addr_i  (addr_i),
  .din_i   (din_i),
  .q_o     (q_o),
  .store_q (store_q)
);

// File: tb/addr_latch_tb_top.sv
module addr_latch_tb_top;
  logic       clk;
  logic       rst;
  logic       clr_n;
  logic       en_n;
  logic [2:0] addr;
  logic       din;
  logic [7:0] q;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model = '0;

  addr_latch #(.ADDR_W(3)) dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .clr_n_i (clr_n),
    .en_n_i  (en_n),
    .addr_i  (addr),
    .din_i   (din),
    .q_o     (q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Expected outputs, from R2, R5, R6 and R9.
  function automatic logic [7:0] exp_q(logic c_n, logic e_n, logic [2:0] a,
                                       logic d, logic [7:0] s);
    if (c_n)       return s;
    else if (!e_n) return d ? (8'b1 << a) : 8'h00;
    else           return 8'h00;
  endfunction

  // Model state after a rising edge, from R1, R3, R4 and R7.
  function automatic logic [7:0] next_s(logic r, logic c_n, logic e_n,
                                        logic [2:0] a, logic d, logic [7:0] s);
    logic [7:0] n = s;
    if (r || !c_n) n = 8'h00;
    else if (!e_n) n[a] = d;
    return n;
  endfunction

  function automatic string tag_of(logic c_n, logic e_n);
    if (c_n && !e_n) return "R3";
    if (c_n && e_n)  return "R4";
    if (!e_n)        return "R5";
    return "R6";
  endfunction

  task automatic check(string req);
    logic [7:0] e = exp_q(clr_n, en_n, addr, din, model);
    n_chk++;
    if (q !== e) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b (clr_n=%b en_n=%b addr=%0d din=%b)",
               req, q, e, clr_n, en_n, addr, din);
    end
  endtask

  task automatic step(logic r, logic c_n, logic e_n, logic [2:0] a, logic d,
                      string req);
    @(negedge clk);
    rst = r; clr_n = c_n; en_n = e_n; addr = a; din = d;
    #1 check(req);
    @(posedge clk);
    model = next_s(r, c_n, e_n, a, d, model);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20250611);
    rst = 1'b1; clr_n = 1'b1; en_n = 1'b1; addr = '0; din = 1'b0;
    repeat (3) @(posedge clk);
    model = '0;
    // R1: reset state seen in hold mode
    step(1'b0, 1'b1, 1'b1, 3'd5, 1'b1, "R1");

    // R3: write ones to bits 0, 3 and 7, then read them back in hold (R9)
    step(1'b0, 1'b1, 1'b0, 3'd0, 1'b1, "R3");
    step(1'b0, 1'b1, 1'b0, 3'd3, 1'b1, "R3");
    step(1'b0, 1'b1, 1'b0, 3'd7, 1'b1, "R3");
    step(1'b0, 1'b1, 1'b1, 3'd2, 1'b1, "R4,R9");
    // R4: hold with other address and data leaves the bits alone
    step(1'b0, 1'b1, 1'b1, 3'd0, 1'b0, "R4");
    step(1'b0, 1'b1, 1'b1, 3'd6, 1'b1, "R4");
    // R3: overwrite bit 3 with 0
    step(1'b0, 1'b1, 1'b0, 3'd3, 1'b0, "R3");
    step(1'b0, 1'b1, 1'b1, 3'd3, 1'b1, "R9");

    // R8: multi-bit address glitches between edges in write mode
    @(negedge clk);
    rst = 1'b0; clr_n = 1'b1; en_n = 1'b0; din = 1'b1; addr = 3'd1;
    #1 addr = 3'd6;
    #1 addr = 3'd4;
    #1 check("R8");
    @(posedge clk);
    model = next_s(1'b0, 1'b1, 1'b0, 3'd4, 1'b1, model);
    step(1'b0, 1'b1, 1'b1, 3'd1, 1'b0, "R8");

    // R5: decode with data high and low, all addresses
    for (int a = 0; a < 8; a++) step(1'b0, 1'b0, 1'b0, 3'(a), 1'b1, "R5");
    step(1'b0, 1'b0, 1'b0, 3'd2, 1'b0, "R5");
    // R7: after decode the bank is empty
    step(1'b0, 1'b1, 1'b1, 3'd0, 1'b0, "R7");

    // R6: fill some bits, then clear with varied address and data
    step(1'b0, 1'b1, 1'b0, 3'd5, 1'b1, "R3");
    step(1'b0, 1'b1, 1'b0, 3'd1, 1'b1, "R3");
    step(1'b0, 1'b0, 1'b1, 3'd5, 1'b1, "R6");
    step(1'b0, 1'b1, 1'b1, 3'd5, 1'b1, "R7");

    // R1: reset in the same cycle as a write
    step(1'b0, 1'b1, 1'b0, 3'd6, 1'b1, "R3");
    step(1'b1, 1'b1, 1'b0, 3'd2, 1'b1, "R1");
    step(1'b0, 1'b1, 1'b1, 3'd2, 1'b0, "R1");

    // Random mix of all modes, with occasional reset (R2 encoding)
    for (int i = 0; i < 1500; i++) begin
      logic r, c, e, d;
      logic [2:0] a;
      r = ($urandom_range(0, 99) < 3);
      c = ($urandom_range(0, 99) < 75);
      e = $urandom_range(0, 1) == 1;
      a = 3'($urandom_range(0, 7));
      d = $urandom_range(0, 1) == 1;
      step(r, c, e, a, d, r ? "R1" : tag_of(c, e));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule